// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Sequencer

This block produces the bus cycles that follow the acceptance of a vectored interrupt on an 8-bit processor whose program counter is 16 bits wide. When the core raises a one-clock accept pulse, the block captures the current program counter, stack pointer and vector table address. It then runs a fixed chain of bus cycles. The chain opens with an acknowledge cycle that carries two built-in wait states. The two program counter bytes are then stored on the stack, growing downward. The two-byte start address is read from the vector table. The chain closes with an opcode fetch from that start address.

Every ordinary bus cycle spans three clock states. The acknowledge cycle spans five. At the end of the chain the block presents the decremented stack pointer and the new program counter to the core, and marks the first state of the opcode fetch with a done pulse. An accept pulse seen while a chain is running has no effect. Address arithmetic wraps modulo 2^16.

Top module: `vint_ack_seq`

## Requirements
- R1: While reset is active, and after it is released with no accept, rd_o, wr_o, ack_o, fetch_o, done_o and busy_o are low, addr_o and wdata_o are zero, and sp_o and pc_o are zero.
- R2: One clock after an accept pulse is sampled in idle, an acknowledge cycle of exactly five clock states starts. In this cycle ack_o is high, addr_o carries the captured program counter, and rd_o and wr_o stay low.
- R3: The next three states form a write cycle to address SP-1 with wdata_o = PC[15:8]. wr_o is high in its second and third state only.
- R4: The next three states form a write cycle to address SP-2 with wdata_o = PC[7:0]. wr_o is high in its second and third state only.
- R5: The next three states form a read cycle at the vector address. rd_o is high in its second and third state, and rdata_i is taken as the start-address low byte at the clock edge that ends the third state.
- R6: The next three states form a read cycle at vector address + 1. rdata_i is taken there as the start-address high byte.
- R7: The last three states form an opcode fetch at {high, low}. fetch_o is high in all three states and rd_o in the second and third. done_o is high for the first state only, after which busy_o falls. busy_o is high in all twenty states of the chain.
- R8: sp_o becomes SP-2 from the first state of the vector-low read, and pc_o becomes {high, low} from the first fetch state. Both then hold until the next chain or reset.
- R9: An accept pulse sampled while busy_o is high starts nothing: the running chain is unchanged, and no acknowledge follows its end.
- R10: Changes on pc_i, sp_i and vec_i after the accept pulse do not alter any address or data of the running chain.
- R11: Stack and vector addresses wrap modulo 2^16 (SP=0x0001 gives 0x0000 then 0xFFFF; vector 0xFFFF gives high-byte address 0x0000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accept_i | input | 1 | One-clock pulse: vectored interrupt accepted |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| vec_i | input | 16 | Vector table entry address |
| rdata_i | input | 8 | Read data from the bus |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Write data (zero outside write cycles) |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| ack_o | output | 1 | Acknowledge cycle in progress |
| fetch_o | output | 1 | Opcode fetch cycle in progress |
| done_o | output | 1 | First state of the opcode fetch |
| busy_o | output | 1 | Chain in progress |
| sp_o | output | 16 | Updated stack pointer |
| pc_o | output | 16 | Updated program counter |

## Verification
The accept pulse is registered, so state k of the chain (k = 0 to 19) is visible in the clock period after the k-th edge that follows the sampling edge. The bus outputs for state k are therefore due k+1 edges after the accept. sp_o is due at state 11 and pc_o at state 17, because each is loaded by the edge that ends the cycle before. The bench drives the accept on a falling edge and samples every output on the following falling edges. It indexes its expectations by the number of edges counted since the accept. Read data comes from a bench memory model that answers on the current address, so the byte taken at the end of each read state follows only from the address presented.

// File: rtl/vas_pkg.sv
package vas_pkg;
  // Bus cycle kinds in the order the sequence visits them.
  typedef enum logic [2:0] {
    CY_IDLE  = 3'd0,
    CY_ACK   = 3'd1,
    CY_PSH_H = 3'd2,
    CY_PSH_L = 3'd3,
    CY_VRD_L = 3'd4,
    CY_VRD_H = 3'd5,
    CY_FETCH = 3'd6
  } cyc_e;
endpackage

// File: rtl/vas_ctrl.sv
module vas_ctrl
  import vas_pkg::*;
#(
  parameter int TSTATES   = 3,
  parameter int ACK_WAITS = 2,
  parameter int CW        = $clog2(TSTATES + ACK_WAITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  output cyc_e          cyc_o,
  output logic [CW-1:0] tcnt_o,
  output logic          last_o,
  output logic          done_o,
  output logic          busy_o
);
  localparam int LONG = TSTATES + ACK_WAITS;

  cyc_e          cyc_q, cyc_d;
  logic [CW-1:0] tcnt_q, tcnt_d;
  logic          last;

  always_comb begin
    unique case (cyc_q)
      CY_IDLE: last = 1'b0;
      CY_ACK:  last = (tcnt_q == CW'(LONG - 1));
      default: last = (tcnt_q == CW'(TSTATES - 1));
    endcase
  end

  always_comb begin
    cyc_d  = cyc_q;
    tcnt_d = tcnt_q;
    if (cyc_q == CY_IDLE) begin
      if (accept_i) begin
        cyc_d  = CY_ACK;
        tcnt_d = '0;
      end
    end else if (last) begin
      tcnt_d = '0;
      unique case (cyc_q)
        CY_ACK:   cyc_d = CY_PSH_H;
        CY_PSH_H: cyc_d = CY_PSH_L;
        CY_PSH_L: cyc_d = CY_VRD_L;
        CY_VRD_L: cyc_d = CY_VRD_H;
        CY_VRD_H: cyc_d = CY_FETCH;
        default:  cyc_d = CY_IDLE;
      endcase
    end else begin
      tcnt_d = CW'(tcnt_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CY_IDLE;
      tcnt_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign cyc_o  = cyc_q;
  assign tcnt_o = tcnt_q;
  assign last_o = last;
  assign busy_o = (cyc_q != CY_IDLE);
  assign done_o = (cyc_q == CY_FETCH) && (tcnt_q == '0);

  // R2: the acknowledge cycle ends after its wait states and moves to the first push
  assert_ack_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CY_ACK && tcnt_q == CW'(LONG - 1)) |=> (cyc_q == CY_PSH_H && tcnt_q == '0));

  // R9: an accept while busy, outside the acknowledge cycle, never leads into one
  assert_busy_accept_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && accept_i && cyc_q != CY_ACK) |=> (cyc_q != CY_ACK));

  // R7: the fetch cycle is always followed by idle
  assert_fetch_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CY_FETCH && last) |=> (cyc_q == CY_IDLE));
endmodule

// File: rtl/vas_capture.sv
module vas_capture #(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          busy_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] vec_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          lat_lo_i,
  input  logic          lat_hi_i,
  input  logic          upd_sp_i,
  output logic [AW-1:0] pc_c_o,
  output logic [AW-1:0] sp_c_o,
  output logic [AW-1:0] vec_c_o,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] pc_o
);
  logic [AW-1:0] pc_c_q, sp_c_q, vec_c_q, sp_q, pc_q;
  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_c_q  <= '0;
      sp_c_q  <= '0;
      vec_c_q <= '0;
    end else if (take_i) begin
      pc_c_q  <= pc_i;
      sp_c_q  <= sp_i;
      vec_c_q <= vec_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else if (lat_lo_i) lo_q <= rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (lat_hi_i) hi_q <= rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else if (upd_sp_i) sp_q <= sp_c_q - AW'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (lat_hi_i) pc_q <= {rdata_i, lo_q};
  end

  assign pc_c_o  = pc_c_q;
  assign sp_c_o  = sp_c_q;
  assign vec_c_o = vec_c_q;
  assign start_o = {hi_q, lo_q};
  assign sp_o    = sp_q;
  assign pc_o    = pc_q;

  // R10: captured inputs hold for the whole sequence
  assert_capture_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(pc_c_q) && $stable(sp_c_q) && $stable(vec_c_q)));

  // R8: the new program counter matches the start address latched with it
  assert_pc_matches_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lat_hi_i |=> (pc_q == {hi_q, lo_q}));
endmodule

// File: rtl/vas_bus.sv
module vas_bus
  import vas_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW,
  parameter int CW = 3
) (
  input  cyc_e          cyc_i,
  input  logic [CW-1:0] tcnt_i,
  input  logic [AW-1:0] pc_c_i,
  input  logic [AW-1:0] sp_c_i,
  input  logic [AW-1:0] vec_c_i,
  input  logic [AW-1:0] start_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          ack_o,
  output logic          fetch_o
);
  logic strobe;
  assign strobe = (tcnt_i != '0);

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    rd_o    = 1'b0;
    wr_o    = 1'b0;
    ack_o   = 1'b0;
    fetch_o = 1'b0;
    unique case (cyc_i)
      CY_ACK: begin
        addr_o = pc_c_i;
        ack_o  = 1'b1;
      end
      CY_PSH_H: begin
        addr_o  = sp_c_i - AW'(1);
        wdata_o = pc_c_i[AW-1:DW];
        wr_o    = strobe;
      end
      CY_PSH_L: begin
        addr_o  = sp_c_i - AW'(2);
        wdata_o = pc_c_i[DW-1:0];
        wr_o    = strobe;
      end
      CY_VRD_L: begin
        addr_o = vec_c_i;
        rd_o   = strobe;
      end
      CY_VRD_H: begin
        addr_o = vec_c_i + AW'(1);
        rd_o   = strobe;
      end
      CY_FETCH: begin
        addr_o  = start_i;
        rd_o    = strobe;
        fetch_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vint_ack_seq.sv
module vint_ack_seq
  import vas_pkg::*;
#(
  parameter int DW        = 8,
  parameter int TSTATES   = 3,
  parameter int ACK_WAITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [2*DW-1:0] sp_i,
  input  logic [2*DW-1:0] vec_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [2*DW-1:0] addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic            ack_o,
  output logic            fetch_o,
  output logic            done_o,
  output logic            busy_o,
  output logic [2*DW-1:0] sp_o,
  output logic [2*DW-1:0] pc_o
);
  localparam int AW = 2 * DW;
  localparam int CW = $clog2(TSTATES + ACK_WAITS);

  // Reset: asserted at once, released on a clock edge after two stages.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cyc_e          cyc;
  logic [CW-1:0] tcnt;
  logic          last, take;
  logic [AW-1:0] pc_c, sp_c, vec_c, start;

  vas_ctrl #(.TSTATES(TSTATES), .ACK_WAITS(ACK_WAITS), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .accept_i(accept_i),
    .cyc_o(cyc), .tcnt_o(tcnt), .last_o(last), .done_o(done_o), .busy_o(busy_o)
  );

  assign take = (cyc == CY_IDLE) && accept_i;

  vas_capture #(.DW(DW), .AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .take_i(take), .busy_i(busy_o),
    .pc_i(pc_i), .sp_i(sp_i), .vec_i(vec_i), .rdata_i(rdata_i),
    .lat_lo_i(cyc == CY_VRD_L && last), .lat_hi_i(cyc == CY_VRD_H && last),
    .upd_sp_i(cyc == CY_PSH_L && last),
    .pc_c_o(pc_c), .sp_c_o(sp_c), .vec_c_o(vec_c), .start_o(start),
    .sp_o(sp_o), .pc_o(pc_o)
  );

  vas_bus #(.DW(DW), .AW(AW), .CW(CW)) u_bus (
    .cyc_i(cyc), .tcnt_i(tcnt), .pc_c_i(pc_c), .sp_c_i(sp_c), .vec_c_i(vec_c),
    .start_i(start), .addr_o(addr_o), .wdata_o(wdata_o), .rd_o(rd_o),
    .wr_o(wr_o), .ack_o(ack_o), .fetch_o(fetch_o)
  );

  // R2: no data strobe during the acknowledge cycle
  assert_ack_quiet_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack_o |-> (!rd_o && !wr_o));

  // R3: read and write strobes never overlap
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(rd_o && wr_o));

  // R7: done marks the first fetch state, before its read strobe
  assert_done_in_fetch_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (fetch_o && !rd_o && busy_o));

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);
endmodule

// File: tb/vint_ack_seq_tb_top.sv
`timescale 1ns/1ps
module vint_ack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept = 1'b0;
  logic [15:0] pc_i = '0, sp_i = '0, vec_i = '0;
  logic [7:0]  rdata;
  logic [15:0] addr_o, sp_o, pc_o;
  logic [7:0]  wdata_o;
  logic        rd_o, wr_o, ack_o, fetch_o, done_o, busy_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // Expectation state held by the bench
  logic [15:0] cur_vec = '0, cur_start = '0, prev_sp = '0, prev_pc = '0;

  always #4 clk = ~clk;

  vint_ack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .pc_i(pc_i), .sp_i(sp_i),
    .vec_i(vec_i), .rdata_i(rdata), .addr_o(addr_o), .wdata_o(wdata_o),
    .rd_o(rd_o), .wr_o(wr_o), .ack_o(ack_o), .fetch_o(fetch_o),
    .done_o(done_o), .busy_o(busy_o), .sp_o(sp_o), .pc_o(pc_o)
  );

  // Memory model: vector table answers at vec and vec+1, everything else 0x5A
  assign rdata = (addr_o == cur_vec) ? cur_start[7:0] :
                 (addr_o == 16'(cur_vec + 16'd1)) ? cur_start[15:8] : 8'h5A;

  // {pc, sp, vec, start}
  localparam logic [63:0] VECS [4] = '{
    {16'h1234, 16'h8000, 16'h0040, 16'h5678},
    {16'hABCD, 16'h0001, 16'hFFFF, 16'h00FF},
    {16'h0000, 16'h0002, 16'h1000, 16'hFFFF},
    {16'hFFFF, 16'h0000, 16'h7FFE, 16'h8001}
  };

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(int k);
    if (k < 5)  return "R2";
    if (k < 8)  return "R3";
    if (k < 11) return "R4";
    if (k < 14) return "R5";
    if (k < 17) return "R6";
    return "R7";
  endfunction

  // Packed bus view: {addr, wdata, rd, wr, ack, fetch, done, busy}
  function automatic logic [29:0] exp_bus(int k, logic [15:0] pc, logic [15:0] sp,
                                          logic [15:0] vec, logic [15:0] st);
    logic [15:0] a; logic [7:0] d; logic r, w, ak, f, dn;
    a = '0; d = '0; r = 0; w = 0; ak = 0; f = 0; dn = 0;
    if (k < 5) begin a = pc; ak = 1; end
    else if (k < 8)  begin a = 16'(sp - 16'd1); d = pc[15:8]; w = (k > 5); end
    else if (k < 11) begin a = 16'(sp - 16'd2); d = pc[7:0];  w = (k > 8); end
    else if (k < 14) begin a = vec; r = (k > 11); end
    else if (k < 17) begin a = 16'(vec + 16'd1); r = (k > 14); end
    else begin a = st; f = 1; r = (k > 17); dn = (k == 17); end
    return {a, d, r, w, ak, f, dn, 1'b1};
  endfunction

  function automatic logic [29:0] bus_now();
    return {addr_o, wdata_o, rd_o, wr_o, ack_o, fetch_o, done_o, busy_o};
  endfunction

  // Run one chain; if disturb, pulse accept and change inputs mid-chain (R9, R10)
  task automatic run_seq(logic [63:0] v, bit disturb);
    logic [15:0] pc, sp, vec, st;
    {pc, sp, vec, st} = v;
    cur_vec = vec; cur_start = st;
    @(negedge clk);
    pc_i = pc; sp_i = sp; vec_i = vec; accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (k > 0) @(negedge clk);
      check(disturb ? {req_of(k), " R9 R10"} : req_of(k), 64'(bus_now()),
            64'(exp_bus(k, pc, sp, vec, st)));
      check("R8 sp_o", 64'(sp_o), 64'((k >= 11) ? 16'(sp - 16'd2) : prev_sp));
      check("R8 pc_o", 64'(pc_o), 64'((k >= 17) ? st : prev_pc));
      if (disturb && k == 5) begin
        accept = 1'b1; pc_i = ~pc; sp_i = ~sp; vec_i = ~vec;
      end
      if (disturb && k == 6) accept = 1'b0;
      if (disturb && k == 19) accept = 1'b1;
    end
    prev_sp = 16'(sp - 16'd2); prev_pc = st;
    @(negedge clk);
    accept = 1'b0;
    check("R7 idle after chain", 64'(bus_now()), 64'(0));
    @(negedge clk);
    check("R9 no acknowledge after ignored accept", 64'({ack_o, busy_o}), 64'(0));
    check("R8 hold", 64'({sp_o, pc_o}), 64'({prev_sp, prev_pc}));
  endtask

  initial begin
    // R1: state during and after reset
    repeat (3) @(negedge clk);
    check("R1 in reset", 64'({bus_now(), sp_o, pc_o}), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 64'({bus_now(), sp_o, pc_o}), 64'(0));

    // Vector table walk: R2..R8, R11 wrap in entries 2 and 4
    for (int i = 0; i < 4; i++) run_seq(VECS[i], 1'b0);

    // R9/R10: accept pulses and changed inputs while busy
    run_seq({16'h2468, 16'h4000, 16'h0100, 16'hBEEF}, 1'b1);

    // R11 explicit: SP=0x0001 pushes land at 0x0000 and 0xFFFF
    cur_vec = 16'hFFFF; cur_start = 16'h00FF;
    @(negedge clk);
    pc_i = 16'h1111; sp_i = 16'h0001; vec_i = 16'hFFFF; accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 push high wraps to 0x0000", 64'(addr_o), 64'h0000);
    repeat (3) @(negedge clk);
    check("R11 push low wraps to 0xFFFF", 64'(addr_o), 64'hFFFF);
    repeat (6) @(negedge clk);
    check("R11 vector+1 wraps to 0x0000", 64'(addr_o), 64'h0000);

    // R1: reset in the middle of a chain returns to the idle state
    repeat (1) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-chain reset", 64'({bus_now(), sp_o, pc_o}), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after second release", 64'({bus_now(), sp_o, pc_o}), 64'(0));
    prev_sp = '0; prev_pc = '0;
    run_seq(VECS[0], 1'b0);

    finish_run();
  end
endmodule